// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is an interval timer that pulls an active-low interrupt line once a programmed time has elapsed. It has no clock divider of its own. It counts single-cycle pulses from a 10 Hz timebase, so 0.5 s is five pulses, 5 s is fifty pulses and 60 s is six hundred pulses. Software programs it through a single register on a small 4-bit address and data bus. A write selects one interval with a one-hot code and chooses between a single interrupt and a repeating one. A read of the same register returns the interval that is currently selected.

Software acknowledges a pending interrupt by reading the register three times in a row. That read sequence releases the line. In repeating mode it also starts the next interval from zero. In single mode the timer stays idle after its one expiry until software writes the register again. To initialise the block, write zero to the register and then read it three times.

Top module: `pit_top`

## Requirements
- R1: After reset `irq_n_o` is 1 and `status_o` is 4'b0000.
- R2: A write (`bus_en`=1, `bus_wr`=1) to address 15 does three things: it takes `bus_wdata[2:0]` as the selection, it releases `irq_n_o` and it restarts the count from zero. The selection codes are 3'b001 for 5 ticks, 3'b010 for 50 ticks and 3'b100 for 600 ticks.
- R3: `status_o[2:0]` shows the stored selection in the same one-hot code, and `status_o[3]` reads 0. The new value is visible from the clock edge that takes the write.
- R4: `irq_n_o` goes low at the clock edge that takes the N-th `tick_10hz` pulse after a restart, where N is the selected tick count. It goes low only at an edge where `tick_10hz` is 1.
- R5: Three consecutive reads (`bus_en`=1, `bus_wr`=0) of address 15 drive `irq_n_o` high from the edge that takes the third read.
- R6: With `bus_wdata[3]`=0 at the write (single mode), the timer counts no further ticks after its one expiry, and an acknowledge does not restart it.
- R7: Any access to another address, and any write, between acknowledge reads restarts the count of consecutive reads, so three further reads are needed.
- R8: With `bus_wdata[3]`=1 at the write (repeat mode), the third acknowledge read also restarts the count from zero. The next expiry then comes N ticks later.
- R9: Writing 3'b000 to the selection disables the timer: `irq_n_o` stays 1 whatever ticks arrive.
- R10: A selection with more than one bit set is stored as 3'b000 and behaves as in R9.
- R11: Accesses to any other address change neither the selection nor the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_10hz | input | 1 | One-cycle timebase pulse, 10 per second |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Register address, 15 selects this timer |
| bus_wdata | input | 4 | Write data: bits 2..0 interval, bit 3 repeat |
| status_o | output | 4 | Selected interval, one-hot, bit 3 zero |
| irq_n_o | output | 1 | Interrupt, low while pending |

## Verification
The assertions assume three things about the inputs. Each access is a single-cycle strobe. `tick_10hz` never stays high for two cycles in a row. No acknowledge read has to compete with an expiry in the same cycle unless the block's documented priority applies. The bench drives every access and every tick from separate tasks, each one cycle long. It does not issue ticks while a read sequence is in progress, so every expiry and every acknowledge lands on a known edge.

// File: rtl/pit_pkg.sv
package pit_pkg;
    typedef logic [2:0] pit_sel_t;

    // Only one-hot codes are accepted; anything else means "disabled".
    function automatic pit_sel_t pit_sel_decode(input logic [2:0] raw);
        return ($countones(raw) == 1) ? raw : 3'b000;
    endfunction
endpackage

// File: rtl/pit_ack_seq.sv
module pit_ack_seq #(
    parameter int ACK_READS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_en,
    input  logic acc_wr,
    input  logic acc_hit,
    output logic ack_o
);
    localparam int AW = $clog2(ACK_READS + 1);

    logic [AW-1:0] run_d, run_q;
    logic          ack_d;

    always_comb begin
        run_d = run_q;
        ack_d = 1'b0;
        if (acc_en) begin
            if (!acc_wr && acc_hit) begin
                if (run_q == AW'(ACK_READS - 1)) begin
                    ack_d = 1'b1;
                    run_d = '0;
                end else begin
                    run_d = run_q + 1'b1;
                end
            end else begin
                run_d = '0;
            end
        end
    end

    assign ack_o = ack_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    AST_ACK_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < AW'(ACK_READS)); // R5

    AST_FOREIGN_RESETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && (acc_wr || !acc_hit)) |=> (run_q == '0)); // R7
endmodule

// File: rtl/pit_interval_cnt.sv
module pit_interval_cnt #(
    parameter int T_SHORT = 5,
    parameter int T_MID   = 50,
    parameter int T_LONG  = 600
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           restart,
    input  pit_pkg::pit_sel_t sel,
    output logic           expire_o
);
    localparam int CW = $clog2(T_LONG + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
    } cnt_state_t;

    cnt_state_t    s_d, s_q;
    logic [CW-1:0] last;
    logic          exp_d;

    always_comb begin
        if (sel[0])      last = CW'(T_SHORT - 1);
        else if (sel[1]) last = CW'(T_MID - 1);
        else             last = CW'(T_LONG - 1);
    end

    always_comb begin
        s_d   = s_q;
        exp_d = 1'b0;
        if (restart) begin
            s_d.cnt = '0;
            s_d.run = (sel != 3'b000);
        end else if (s_q.run && tick) begin
            if (s_q.cnt == last) begin
                exp_d   = 1'b1;
                s_d.cnt = '0;
                s_d.run = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    assign expire_o = exp_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < CW'(T_LONG)); // R2

    AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !restart) |=> $stable(s_q.cnt)); // R6
endmodule

// File: rtl/pit_top.sv
module pit_top #(
    parameter int          T_SHORT   = 5,
    parameter int          T_MID     = 50,
    parameter int          T_LONG    = 600,
    parameter int          ACK_READS = 3,
    parameter logic [3:0]  PIT_ADDR  = 4'hF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_10hz,
    input  logic       bus_en,
    input  logic       bus_wr,
    input  logic [3:0] bus_addr,
    input  logic [3:0] bus_wdata,
    output logic [3:0] status_o,
    output logic       irq_n_o
);
    import pit_pkg::*;

    typedef struct packed {
        pit_sel_t sel;
        logic     rep;
        logic     irq;
    } top_state_t;

    top_state_t s_d, s_q;
    logic       hit, wr_hit, ack, expire, restart;

    assign hit     = (bus_addr == PIT_ADDR);
    assign wr_hit  = bus_en && bus_wr && hit;
    assign restart = wr_hit || (ack && s_q.rep);

    pit_ack_seq #(.ACK_READS(ACK_READS)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (bus_en),
        .acc_wr  (bus_wr),
        .acc_hit (hit),
        .ack_o   (ack)
    );

    pit_interval_cnt #(.T_SHORT(T_SHORT), .T_MID(T_MID), .T_LONG(T_LONG)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_10hz),
        .restart  (restart),
        .sel      (wr_hit ? pit_sel_decode(bus_wdata[2:0]) : s_q.sel),
        .expire_o (expire)
    );

    always_comb begin
        s_d = s_q;
        if (wr_hit) begin
            s_d.sel = pit_sel_decode(bus_wdata[2:0]);
            s_d.rep = bus_wdata[3];
            s_d.irq = 1'b0;
        end else begin
            if (ack)    s_d.irq = 1'b0;
            if (expire) s_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_o = {1'b0, s_q.sel};
    assign irq_n_o  = !s_q.irq;

    AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> $past(tick_10hz)); // R4

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !tick_10hz) |=> irq_n_o); // R5

    AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> irq_n_o); // R2

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2:0] == 3'b000) |-> irq_n_o); // R9

    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_o[2:0]) && !status_o[3]); // R10
endmodule

// File: tb/pit_top_tb_top.sv
module pit_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_10hz = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [3:0] bus_wdata = 4'h0;
    logic [3:0] status_o;
    logic       irq_n_o;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pit_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_10hz (tick_10hz),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status_o  (status_o),
        .irq_n_o   (irq_n_o)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_10hz = 1'b1;
            @(negedge clk) tick_10hz = 1'b0;
        end
    endtask

    task automatic access(input logic wr, input logic [3:0] addr, input logic [3:0] data);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic ack3();
        for (int i = 0; i < 3; i++) access(1'b0, 4'hF, 4'h0);
    endtask

    task automatic t_reset();
        check("R1 irq", {3'b0, irq_n_o}, 4'h1);
        check("R1 status", status_o, 4'h0);
    endtask

    task automatic t_short_single();
        access(1'b1, 4'hF, 4'b0001);
        check("R3 status short", status_o, 4'b0001);
        ticks(4);
        check("R4 before expiry", {3'b0, irq_n_o}, 4'h1);
        ticks(1);
        check("R4 expiry 5", {3'b0, irq_n_o}, 4'h0);
        ack3();
        check("R5 ack releases", {3'b0, irq_n_o}, 4'h1);
        ticks(12);
        check("R6 single stays idle", {3'b0, irq_n_o}, 4'h1);
    endtask

    task automatic t_mid_repeat();
        access(1'b1, 4'hF, 4'b1010);
        check("R3 status mid", status_o, 4'b0010);
        ticks(49);
        check("R2 before 50", {3'b0, irq_n_o}, 4'h1);
        ticks(1);
        check("R2 expiry 50", {3'b0, irq_n_o}, 4'h0);
        access(1'b0, 4'hF, 4'h0);
        access(1'b0, 4'hF, 4'h0);
        access(1'b1, 4'h7, 4'h0);
        check("R11 foreign write keeps sel", status_o, 4'b0010);
        access(1'b0, 4'hF, 4'h0);
        access(1'b0, 4'hF, 4'h0);
        check("R7 broken sequence", {3'b0, irq_n_o}, 4'h0);
        access(1'b0, 4'hF, 4'h0);
        check("R7 third fresh read", {3'b0, irq_n_o}, 4'h1);
        ticks(49);
        check("R8 restart 49", {3'b0, irq_n_o}, 4'h1);
        ticks(1);
        check("R8 restart 50", {3'b0, irq_n_o}, 4'h0);
        ack3();
    endtask

    task automatic t_long_disable();
        access(1'b1, 4'hF, 4'b0100);
        check("R3 status long", status_o, 4'b0100);
        ticks(300);
        access(1'b0, 4'h3, 4'h0);
        ticks(299);
        check("R11 count kept 599", {3'b0, irq_n_o}, 4'h1);
        ticks(1);
        check("R4 expiry 600", {3'b0, irq_n_o}, 4'h0);
        access(1'b1, 4'hF, 4'b1000);
        check("R9 write zero releases", {3'b0, irq_n_o}, 4'h1);
        check("R9 status zero", status_o, 4'h0);
        ticks(650);
        check("R9 stays quiet", {3'b0, irq_n_o}, 4'h1);
    endtask

    task automatic t_multi_hot();
        access(1'b1, 4'hF, 4'b0011);
        check("R10 status", status_o, 4'h0);
        ticks(60);
        check("R10 quiet", {3'b0, irq_n_o}, 4'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_single();
        t_mid_repeat();
        t_long_disable();
        t_multi_hot();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule